// File: doc/BRIEF.md
# Packet Page Allocator with Queues

This block keeps a small pool of fixed-size packet pages for an Ethernet controller. Each page is 2048 bytes and is tracked by one bit in a busy map. The block holds three page-number queues: pages waiting to be sent, pages whose send has finished, and pages that hold received frames. A host writes a command byte, and the top three bits of that byte choose the operation. The receive path asks for a page with a request strobe. A send engine takes one queued page per cycle and raises a strobe for it.

The block reports the result of the last transmit allocation, the head of the send-done queue, the head of the receive queue, the number of busy pages and four interrupt levels. The packet RAM, the host register decode and the real frame transmission all sit outside this block.

A transmit allocation that finds no free page stays pending. While the allocation result reads 0x80, every later page release retries that allocation at once. When auto-release is on, each page is freed as soon as it is sent and is not pushed to the send-done queue.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset the allocation result is 0, both queue heads read 0x80, no page is busy, the transmit-empty interrupt is 1, the other interrupts are 0, and `total_pages` reads 4.
- R2: A command byte with bits 7:5 = 1 (allocate for transmit) sets the allocation result to the lowest-numbered free page, marks that page busy and sets `irq_alloc`. All command effects appear in the cycle after the command.
- R3: An allocate command while all four pages are busy sets the allocation result to 0x80 and clears `irq_alloc`.
- R4: While the allocation result is 0x80, any page release (command 5, command 4, or a send with auto-release) retries the allocation in the same cycle. A successful retry stores the page number and sets `irq_alloc`.
- R5: Command 6 appends `pkt_num` to the send queue. It is ignored when the send queue already holds four entries. `irq_tx_empty` is 1 exactly when the send queue is empty.
- R6: When `tx_enable` is 1, the send queue is not empty and no command is valid, the head page is sent: `send_valid` is 1 and `send_page` shows the head, and the page leaves the queue. With auto-release the page is freed. Without it, the page is appended to the send-done queue if that queue has room, and `irq_tx` is 1 while the send-done queue is not empty.
- R7: `done_pop` removes the send-done head. `done_head` reads 0x80 when that queue is empty.
- R8: `rx_req` is granted when no command is valid, no send is taking place and a page is free. The grant gives the lowest free page, marks it busy and appends it to the receive queue.
- R9: Command 3 pops the receive queue and the remaining entries move forward. `irq_rcv` is 1 while entries remain. `rx_head` reads 0x80 when the queue is empty, and a pop of an empty queue has no effect.
- R10: Command 4 releases the receive head page and then pops it.
- R11: Command 2 clears the busy map and all three queues, and sets the allocation result to 0.
- R12: Command 7 empties the send and send-done queues and leaves the busy map unchanged.
- R13: Command 0 has no effect, and bits 4:0 of the command byte are ignored.
- R14: `used_pages` gives the number of busy pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte is valid this cycle |
| cmd_byte | input | 8 | Command byte; bits 7:5 select the operation |
| pkt_num | input | 2 | Page named by commands 5 and 6 |
| tx_enable | input | 1 | Allows the send engine to run |
| auto_release | input | 1 | Free each page when it is sent |
| rx_req | input | 1 | Receive path asks for a page |
| done_pop | input | 1 | Remove the send-done head |
| rx_grant | output | 1 | Receive request accepted this cycle |
| rx_page | output | 2 | Page given to the receive path |
| send_valid | output | 1 | A page is sent this cycle |
| send_page | output | 2 | Page being sent |
| alloc_result | output | 8 | Last transmit allocation, 0x80 when pending |
| done_head | output | 8 | Send-done head, 0x80 when empty |
| rx_head | output | 8 | Receive head, 0x80 when empty |
| used_pages | output | 3 | Number of busy pages |
| total_pages | output | 3 | Pool size (4) |
| irq_alloc | output | 1 | Transmit allocation succeeded |
| irq_rcv | output | 1 | Receive queue not empty |
| irq_tx_empty | output | 1 | Send queue empty |
| irq_tx | output | 1 | Send-done queue not empty |

## Verification
The assertions assume that `pkt_num` names a page of the pool, which its two-bit width guarantees. They also assume the host may release a page it does not own or queue the same page twice. The properties are therefore written so they hold in those cases too, for example the auto-release check is skipped while an allocation is pending. The sweep draws every command code with random low bits and random page numbers, and it mixes in random send, receive and pop strobes. Because the stimulus never depends on how the design arbitrates, it exercises overlaps of commands, sends and receive requests freely. Command 2 is kept rare so the pool reaches its full and overflowing states often.

// File: rtl/pkt_page_pkg.sv
// Shared types for the packet page allocator.
// Assumes pools of at most 128 pages so a page number fits below 0x80.
package pkt_page_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_TX_ALLOC = 3'd1,
        OP_WIPE     = 3'd2,
        OP_RX_DROP  = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_FREE     = 3'd5,
        OP_TX_QUEUE = 3'd6,
        OP_TX_FLUSH = 3'd7
    } page_op_e;

    localparam logic [7:0] NO_PAGE = 8'h80;

endpackage

// File: rtl/free_page_pick.sv
// Finds the lowest-numbered clear bit of a busy map.
// Purely combinational; assumes PAGES >= 2.
module free_page_pick #(
    parameter int PAGES = 4,
    localparam int IW = $clog2(PAGES)
) (
    input  logic [PAGES-1:0] busy,
    output logic [IW-1:0]    idx,
    output logic             found
);

    // scan from the top so the lowest free page wins
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = PAGES - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/page_fifo.sv
// Shift-forward queue of page numbers; entry 0 is always the head.
// A push into a full queue is accepted only when a pop frees a slot in the
// same cycle; otherwise it is dropped. Clear overrides push and pop.
module page_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  slot [DEPTH];
    logic          pop_ok;
    logic          push_ok;
    logic [CW-1:0] wr_idx;

    // accept decisions and write position after an optional pop
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        wr_idx  = count - CW'(pop_ok);
        head    = slot[0];
    end

    // occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else begin
            count <= count - CW'(pop_ok) + CW'(push_ok);
        end
    end

    // entry storage: shift forward on pop, write at the tail on push
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (push_ok && CW'(i) == wr_idx) begin
                slot[i] <= din;
            end else if (pop_ok && i < DEPTH - 1) begin
                slot[i] <= slot[(i < DEPTH - 1) ? i + 1 : i];
            end
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));

    p_pop_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !clr) |=> (count == $past(count) - CW'(1)));

endmodule

// File: rtl/pkt_page_mgr.sv
// Packet page allocator: busy map, send / send-done / receive queues,
// command decode and interrupt levels.
// Assumes one command, one send and one receive grant at most per cycle;
// a valid command blocks the send engine, and both block receive grants.
module pkt_page_mgr
    import pkt_page_pkg::*;
#(
    parameter int NPAGES = 4,
    localparam int PW = $clog2(NPAGES),
    localparam int CW = $clog2(NPAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_byte,
    input  logic [PW-1:0] pkt_num,
    input  logic          tx_enable,
    input  logic          auto_release,
    input  logic          rx_req,
    input  logic          done_pop,
    output logic          rx_grant,
    output logic [PW-1:0] rx_page,
    output logic          send_valid,
    output logic [PW-1:0] send_page,
    output logic [7:0]    alloc_result,
    output logic [7:0]    done_head,
    output logic [7:0]    rx_head,
    output logic [CW-1:0] used_pages,
    output logic [CW-1:0] total_pages,
    output logic          irq_alloc,
    output logic          irq_rcv,
    output logic          irq_tx_empty,
    output logic          irq_tx
);

    logic [NPAGES-1:0] busy;
    logic [NPAGES-1:0] busy_mid;
    logic [NPAGES-1:0] busy_nxt;
    page_op_e          op;
    logic              do_alloc, do_wipe, do_rx_drop, do_rx_free;
    logic              do_free, do_queue, do_flush;
    logic              send_fire, rx_ok, rel_en, pending, tx_take;
    logic [PW-1:0]     rel_page, pick_idx;
    logic              pick_ok;
    logic [PW-1:0]     txq_head, dnq_head, rxq_head;
    logic [CW-1:0]     txq_cnt, dnq_cnt, rxq_cnt;
    logic              txq_empty, dnq_empty, rxq_empty;
    logic              txq_full, dnq_full, rxq_full;

    // command decode from the top three bits of the byte
    always_comb begin
        op         = page_op_e'(cmd_byte[7:5]);
        do_alloc   = cmd_valid && (op == OP_TX_ALLOC);
        do_wipe    = cmd_valid && (op == OP_WIPE);
        do_rx_drop = cmd_valid && (op == OP_RX_DROP);
        do_rx_free = cmd_valid && (op == OP_RX_FREE);
        do_free    = cmd_valid && (op == OP_FREE);
        do_queue   = cmd_valid && (op == OP_TX_QUEUE);
        do_flush   = cmd_valid && (op == OP_TX_FLUSH);
    end

    // arbitration between commands, the send engine and receive requests
    always_comb begin
        send_fire = tx_enable && !txq_empty && !cmd_valid;
        rx_ok     = rx_req && !cmd_valid && !send_fire && !(&busy);
        rel_en    = do_free || (do_rx_free && !rxq_empty) || (send_fire && auto_release);
        if (do_free) begin
            rel_page = pkt_num;
        end else if (do_rx_free) begin
            rel_page = rxq_head;
        end else begin
            rel_page = txq_head;
        end
    end

    // busy map after a release, before any new allocation
    always_comb begin
        busy_mid = busy;
        if (rel_en) begin
            busy_mid[rel_page] = 1'b0;
        end
    end

    free_page_pick #(.PAGES(NPAGES)) u_pick (
        .busy  (busy_mid),
        .idx   (pick_idx),
        .found (pick_ok)
    );

    // transmit allocation now or retried by a release while pending
    always_comb begin
        pending  = (alloc_result == NO_PAGE);
        tx_take  = pick_ok && (do_alloc || (rel_en && pending));
        busy_nxt = busy_mid;
        if (tx_take || rx_ok) begin
            busy_nxt[pick_idx] = 1'b1;
        end
        if (do_wipe) begin
            busy_nxt = '0;
        end
    end

    // busy map register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
        end else begin
            busy <= busy_nxt;
        end
    end

    // allocation result and its interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_result <= 8'h00;
            irq_alloc    <= 1'b0;
        end else if (do_wipe) begin
            alloc_result <= 8'h00;
        end else if (tx_take) begin
            alloc_result <= {{(8 - PW){1'b0}}, pick_idx};
            irq_alloc    <= 1'b1;
        end else if (do_alloc) begin
            alloc_result <= NO_PAGE;
            irq_alloc    <= 1'b0;
        end
    end

    page_fifo #(.DEPTH(NPAGES), .W(PW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_wipe || do_flush),
        .push  (do_queue),
        .pop   (send_fire),
        .din   (pkt_num),
        .head  (txq_head),
        .count (txq_cnt),
        .empty (txq_empty),
        .full  (txq_full)
    );

    page_fifo #(.DEPTH(NPAGES), .W(PW)) u_dnq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_wipe || do_flush),
        .push  (send_fire && !auto_release),
        .pop   (done_pop),
        .din   (txq_head),
        .head  (dnq_head),
        .count (dnq_cnt),
        .empty (dnq_empty),
        .full  (dnq_full)
    );

    page_fifo #(.DEPTH(NPAGES), .W(PW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_wipe),
        .push  (rx_ok),
        .pop   (do_rx_drop || do_rx_free),
        .din   (pick_idx),
        .head  (rxq_head),
        .count (rxq_cnt),
        .empty (rxq_empty),
        .full  (rxq_full)
    );

    // status outputs derived from registered state
    always_comb begin
        used_pages = '0;
        for (int i = 0; i < NPAGES; i++) begin
            used_pages = used_pages + CW'(busy[i]);
        end
        total_pages  = CW'(NPAGES);
        done_head    = dnq_empty ? NO_PAGE : {{(8 - PW){1'b0}}, dnq_head};
        rx_head      = rxq_empty ? NO_PAGE : {{(8 - PW){1'b0}}, rxq_head};
        irq_rcv      = !rxq_empty;
        irq_tx_empty = txq_empty;
        irq_tx       = !dnq_empty;
        rx_grant     = rx_ok;
        rx_page      = pick_idx;
        send_valid   = send_fire;
        send_page    = txq_head;
    end

    p_alloc_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_alloc && (&busy)) |=> (alloc_result == NO_PAGE && !irq_alloc));

    p_grant_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_grant |=> busy[$past(rx_page)]);

    p_flush_queues_r12: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> (irq_tx_empty && !irq_tx));

    p_auto_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send_valid && auto_release && alloc_result != NO_PAGE) |=> !busy[$past(send_page)]);

    p_wipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        do_wipe |=> (used_pages == '0 && rx_head == NO_PAGE && alloc_result == 8'h00));

endmodule

// File: tb/pkt_page_mgr_test.sv
// Bench for pkt_page_mgr: directed corner cases, then a long mixed sweep
// compared cycle by cycle against a behavioural model built from the brief.
module pkt_page_mgr_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [1:0] pkt_num = 2'd0;
    logic       tx_enable = 1'b0, auto_release = 1'b0, rx_req = 1'b0, done_pop = 1'b0;
    logic       rx_grant, send_valid;
    logic [1:0] rx_page, send_page;
    logic [7:0] alloc_result, done_head, rx_head;
    logic [2:0] used_pages, total_pages;
    logic       irq_alloc, irq_rcv, irq_tx_empty, irq_tx;

    int total = 0;
    int bad = 0;

    // model state
    int m_bm, m_res, m_ia;
    int tq[4], dq[4], rq[4];
    int tl, dl, rl;
    int unsigned seed = 32'h1234_5677;

    always #4 clk = ~clk;

    pkt_page_mgr uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .pkt_num(pkt_num), .tx_enable(tx_enable), .auto_release(auto_release),
        .rx_req(rx_req), .done_pop(done_pop), .rx_grant(rx_grant), .rx_page(rx_page),
        .send_valid(send_valid), .send_page(send_page), .alloc_result(alloc_result),
        .done_head(done_head), .rx_head(rx_head), .used_pages(used_pages),
        .total_pages(total_pages), .irq_alloc(irq_alloc), .irq_rcv(irq_rcv),
        .irq_tx_empty(irq_tx_empty), .irq_tx(irq_tx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < 4; i++) if (((m_bm >> i) & 1) == 0) return i;
        return -1;
    endfunction

    function automatic int bits_set();
        int n = 0;
        for (int i = 0; i < 4; i++) n += (m_bm >> i) & 1;
        return n;
    endfunction

    function automatic int unsigned nxt();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic m_try_alloc();
        int p = lowest_free();
        if (p >= 0) begin
            m_bm |= 1 << p;
            m_res = p;
            m_ia = 1;
        end
    endtask

    task automatic m_release(input int p);
        m_bm &= ~(1 << p);
        if (m_res == 'h80) m_try_alloc();
    endtask

    task automatic m_pop_rx();
        for (int i = 0; i < 3; i++) rq[i] = rq[i + 1];
        rl--;
    endtask

    task automatic m_reset();
        m_bm = 0; m_res = 0; m_ia = 0; tl = 0; dl = 0; rl = 0;
    endtask

    // one cycle: drive, check strobes, update model, check registered outputs
    task automatic step(input bit cv, input logic [7:0] cb, input int pn,
                        input bit te, input bit ar, input bit rr, input bit dp);
        bit es, eg;
        int sp, code;
        cmd_valid = cv; cmd_byte = cb; pkt_num = pn[1:0];
        tx_enable = te; auto_release = ar; rx_req = rr; done_pop = dp;
        #1;
        es = te && tl > 0 && !cv;
        eg = rr && !cv && !es && m_bm != 15;
        chk("R6 send_valid", send_valid, es);
        if (es) chk("R6 send_page", send_page, tq[0]);
        chk("R8 rx_grant", rx_grant, eg);
        if (eg) chk("R8 rx_page", rx_page, lowest_free());
        if (dp && dl > 0) begin
            for (int i = 0; i < 3; i++) dq[i] = dq[i + 1];
            dl--;
        end
        code = cb[7:5];
        if (cv) begin
            case (code)
                1: begin m_res = 'h80; m_ia = 0; m_try_alloc(); end
                2: begin m_bm = 0; tl = 0; dl = 0; rl = 0; m_res = 0; end
                3: if (rl > 0) m_pop_rx();
                4: if (rl > 0) begin m_release(rq[0]); m_pop_rx(); end
                5: m_release(pn);
                6: if (tl < 4) begin tq[tl] = pn; tl++; end
                7: begin tl = 0; dl = 0; end
                default: ;
            endcase
        end
        if (es) begin
            sp = tq[0];
            for (int i = 0; i < 3; i++) tq[i] = tq[i + 1];
            tl--;
            if (ar) m_release(sp);
            else if (dl < 4) begin dq[dl] = sp; dl++; end
        end
        if (eg) begin
            sp = lowest_free();
            m_bm |= 1 << sp;
            if (rl < 4) begin rq[rl] = sp; rl++; end
        end
        @(posedge clk); #1;
        chk("R2 alloc_result", alloc_result, m_res);
        chk("R2 irq_alloc", irq_alloc, m_ia);
        chk("R7 done_head", done_head, dl > 0 ? dq[0] : 'h80);
        chk("R9 rx_head", rx_head, rl > 0 ? rq[0] : 'h80);
        chk("R9 irq_rcv", irq_rcv, rl > 0);
        chk("R5 irq_tx_empty", irq_tx_empty, tl == 0);
        chk("R6 irq_tx", irq_tx, dl > 0);
        chk("R14 used_pages", used_pages, bits_set());
        @(negedge clk);
    endtask

    task automatic op(input int code, input int pn);
        step(1'b1, 8'(code << 5), pn, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 alloc_result", alloc_result, 0);
        chk("R1 done_head", done_head, 'h80);
        chk("R1 rx_head", rx_head, 'h80);
        chk("R1 used_pages", used_pages, 0);
        chk("R1 irq_tx_empty", irq_tx_empty, 1);
        chk("R1 irq_other", {irq_alloc, irq_rcv, irq_tx}, 0);
        chk("R1 total_pages", total_pages, 4);
        // R2 fill the pool in order
        for (int i = 0; i < 4; i++) begin
            op(1, 0);
            chk("R2 lowest page", alloc_result, i);
        end
        op(1, 0);
        chk("R3 full result", alloc_result, 'h80);
        chk("R3 irq_alloc cleared", irq_alloc, 0);
        op(5, 1);
        chk("R4 retry on release", alloc_result, 1);
        chk("R4 irq_alloc", irq_alloc, 1);
        for (int i = 0; i < 5; i++) op(6, i & 3);
        chk("R5 queue not empty", irq_tx_empty, 0);
        op(7, 0);
        chk("R12 flushed", irq_tx_empty, 1);
        chk("R12 map kept", used_pages, 4);
        op(2, 0);
        chk("R11 wipe used", used_pages, 0);
        chk("R11 wipe result", alloc_result, 0);
        step(1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 rx head", rx_head, 0);
        step(1'b1, 8'h1F, 3, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R13 no-op low bits", used_pages, 2);
        op(4, 0);
        chk("R10 free and pop head", rx_head, 1);
        chk("R10 freed", used_pages, 1);
        op(3, 0);
        chk("R9 empty head", rx_head, 'h80);
        chk("R9 irq_rcv low", irq_rcv, 0);
        op(3, 0);
        chk("R9 empty pop ignored", used_pages, 1);
        // mixed sweep
        for (int n = 0; n < 4000; n++) begin
            int unsigned r = nxt();
            int code = (r >> 1) & 7;
            if (code == 2 && ((r >> 20) & 7) != 0) code = 6;
            step(r[0], 8'((code << 5) | ((r >> 4) & 31)), (r >> 9) & 3,
                 r[11], r[12], r[13], r[14] & r[15]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule